// File: doc/BRIEF.md
# Baud-Framed Serial Sample Deserializer

This block is the receiving end of a serial link from a host processor into the transmit path of a converter front end. The host supplies a master clock and a frame-sync pulse at the symbol rate. One symbol period lasts exactly 48 master-clock periods, and one frame of 48 serial bits arrives during it. The block waits for the sync, shifts the frame in one bit per rising clock edge and splits it into two 16-bit two's-complement sample words and two 8-bit control bytes.

Each sample word is passed to the DAC side with a one-cycle strobe as soon as its last bit arrives, so the DAC is updated twice per symbol. The two control bytes are held in output registers that change only at the end of a frame, and a one-cycle strobe marks each change. A sync that is still high on the edge that takes the last bit of a frame starts the next frame at once, so frames can run back to back with no idle cycle.

Top module: `baud_frame_deser`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and clears any frame in progress. After reset the block waits for sync and raises no strobe while sync stays low.
- R2: When the block is idle and sees sync high on a rising edge, bit 0 of the frame is taken on the next rising edge. Bits 1 to 47 follow on the 47 edges after that.
- R3: While a frame is in progress, sync is not looked at, so extra sync pulses or a long sync level inside a frame change nothing. If sync is low at the end of the frame, the block goes idle.
- R4: The frame is sent MSB first in this order: word0[15:0], ctrl0[7:0], word1[15:0], ctrl1[7:0]. After the edge that takes bit 15, the block drives `dac_word_o` with word0, sets `dac_sel_o` to 0 and sets `dac_stb_o` to 1.
- R5: After the edge that takes bit 39, the block drives `dac_word_o` with word1, sets `dac_sel_o` to 1 and sets `dac_stb_o` to 1. This gives exactly two DAC strobes per frame, 24 cycles apart.
- R6: After the edge that takes bit 47, `ctrl0_o` and `ctrl1_o` load the frame's two control bytes and `ctrl_stb_o` pulses. At no other time do these registers change.
- R7: If sync is high on the edge that takes bit 47, that edge also counts as the sync of a new frame. Its bit 0 is taken on the next edge, so frames repeat every 48 cycles.
- R8: A sync pulse that is high for only one master-clock period starts a frame.
- R9: Each strobe lasts exactly one cycle. `dac_word_o` and `dac_sel_o` keep their values between DAC strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; everything happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame-sync from the host, at the symbol rate |
| sdata_i | input | 1 | Serial frame data, MSB first |
| dac_word_o | output | 16 | Latest sample word for the DAC, two's complement |
| dac_sel_o | output | 1 | 0 when the word is word0, 1 when it is word1 |
| dac_stb_o | output | 1 | One-cycle strobe when a new sample word is driven |
| ctrl0_o | output | 8 | Held first control byte |
| ctrl1_o | output | 8 | Held second control byte |
| ctrl_stb_o | output | 1 | One-cycle strobe when the control bytes update |

## Verification
The assertions watch the frame sequencer on every cycle. They check that an idle block starts a frame on sync, that a running frame cannot be stopped by sync, and that sync at the last bit restarts the count at zero. On the output side they check that the strobes last one cycle and that the control bytes stay still between frame ends. Only the bench scenarios can show that each word and control byte comes from the correct bit positions at the correct cycle. The same goes for back-to-back framing with a 48-cycle period, for sync pulses inside a frame having no effect, and for reset in the middle of a frame.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

   typedef enum logic {
      BFD_IDLE = 1'b0,
      BFD_RUN  = 1'b1
   } bfd_state_e;

   // Bits carried by one sample slot: one data word plus its control byte.
   function automatic int bfd_slot_bits(input int word_w, input int ctl_w);
      return word_w + ctl_w;
   endfunction

endpackage

// File: rtl/bfd_seq.sv
module bfd_seq
   import bfd_pkg::*;
#(
   parameter int FRAME_W = 48,
   localparam int CNT_W  = $clog2(FRAME_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_i,
   output logic             run_o,
   output logic [CNT_W-1:0] idx_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

   bfd_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= BFD_IDLE;
         cnt_q   <= '0;
      end else if (state_q == BFD_IDLE) begin
         cnt_q <= '0;
         if (sync_i) state_q <= BFD_RUN;
      end else if (cnt_q == LAST_IDX) begin
         cnt_q   <= '0;
         state_q <= sync_i ? BFD_RUN : BFD_IDLE;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign run_o  = (state_q == BFD_RUN);
   assign idx_o  = cnt_q;
   assign last_o = run_o && (cnt_q == LAST_IDX);

   // R2
   start_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_o && sync_i) |=> (run_o && idx_o == '0));

   // R3
   frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run_o && !last_o) |=> (run_o && idx_o == $past(idx_o) + 1'b1));

   // R7
   back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
      (last_o && sync_i) |=> (run_o && idx_o == '0));

   // R3
   idle_after_end_chk: assert property (@(posedge clk) disable iff (rst)
      (last_o && !sync_i) |=> !run_o);

endmodule

// File: rtl/bfd_shift.sv
module bfd_shift #(
   parameter int FRAME_W = 48
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en_i,
   input  logic               sdata_i,
   output logic [FRAME_W-1:0] frame_o
);

   logic [FRAME_W-2:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)       hist_q <= '0;
      else if (en_i) hist_q <= {hist_q[FRAME_W-3:0], sdata_i};
   end

   // The full frame as it stands once the bit now on the input is taken.
   assign frame_o = {hist_q, sdata_i};

endmodule

// File: rtl/baud_frame_deser.sv
module baud_frame_deser
   import bfd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int CTL_W   = 8,
   localparam int NSLOT   = 2,
   localparam int SLOT_W  = bfd_slot_bits(WORD_W, CTL_W),
   localparam int FRAME_W = NSLOT * SLOT_W,
   localparam int CNT_W   = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sync_i,
   input  logic              sdata_i,
   output logic [WORD_W-1:0] dac_word_o,
   output logic              dac_sel_o,
   output logic              dac_stb_o,
   output logic [CTL_W-1:0]  ctrl0_o,
   output logic [CTL_W-1:0]  ctrl1_o,
   output logic              ctrl_stb_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("baud_frame_deser: WORD_W must be at least 2");
   end
   if (CTL_W < 1) begin : g_bad_ctl
      $error("baud_frame_deser: CTL_W must be at least 1");
   end

   logic               run;
   logic [CNT_W-1:0]   idx;
   logic               last;
   logic [FRAME_W-1:0] frame;
   logic [NSLOT-1:0]   word_hit;
   logic [CTL_W-1:0]   ctl_q [NSLOT];
   logic               chk_arm_q;

   bfd_seq #(.FRAME_W(FRAME_W)) u_seq (
      .clk    (clk),
      .rst    (rst),
      .sync_i (sync_i),
      .run_o  (run),
      .idx_o  (idx),
      .last_o (last)
   );

   bfd_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst     (rst),
      .en_i    (run),
      .sdata_i (sdata_i),
      .frame_o (frame)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam logic [CNT_W-1:0] WORD_END = CNT_W'(s * SLOT_W + WORD_W - 1);
      localparam int CTL_LSB = FRAME_W - (s + 1) * SLOT_W;

      assign word_hit[s] = run && (idx == WORD_END);

      always_ff @(posedge clk) begin
         if (rst)       ctl_q[s] <= '0;
         else if (last) ctl_q[s] <= frame[CTL_LSB +: CTL_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_word_o <= '0;
         dac_sel_o  <= 1'b0;
         dac_stb_o  <= 1'b0;
         ctrl_stb_o <= 1'b0;
         chk_arm_q  <= 1'b0;
      end else begin
         dac_stb_o  <= |word_hit;
         ctrl_stb_o <= last;
         chk_arm_q  <= 1'b1;
         if (|word_hit) begin
            dac_word_o <= frame[WORD_W-1:0];
            dac_sel_o  <= word_hit[1];
         end
      end
   end

   assign ctrl0_o = ctl_q[0];
   assign ctrl1_o = ctl_q[1];

   // R9
   dac_stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dac_stb_o |=> !dac_stb_o);

   // R9
   ctrl_stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_stb_o |=> !ctrl_stb_o);

   // R6
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
      !ctrl_stb_o |-> (ctrl0_o == $past(ctrl0_o) && ctrl1_o == $past(ctrl1_o)));

   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (rst || !chk_arm_q)
      !dac_stb_o |-> (dac_word_o == $past(dac_word_o) && dac_sel_o == $past(dac_sel_o)));

endmodule

// File: tb/tb_baud_frame_deser.sv
module tb_baud_frame_deser;

   localparam int CLK_P = 10;
   localparam int NV    = 4;

   // Frame vectors: {word0, ctrl0, word1, ctrl1}, MSB first on the wire.
   localparam logic [47:0] VEC [NV] = '{
      {16'h8001, 8'hA5, 16'h7FFE, 8'h3C},
      {16'h1234, 8'h0F, 16'hFEDC, 8'hF0},
      {16'hFFFF, 8'h81, 16'h0000, 8'h7E},
      {16'h5A5A, 8'hC3, 16'hA5A5, 8'h18}
   };
   // Mode bits: [1] = chain the next frame back to back, [0] = extra sync pulses inside the frame
   localparam logic [1:0] MODE [NV] = '{2'b00, 2'b10, 2'b01, 2'b00};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sync_i = 1'b0;
   logic        sdata_i = 1'b0;
   logic [15:0] dac_word_o;
   logic        dac_sel_o;
   logic        dac_stb_o;
   logic [7:0]  ctrl0_o;
   logic [7:0]  ctrl1_o;
   logic        ctrl_stb_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic        pend = 1'b0;
   logic [47:0] pend_f = '0;

   baud_frame_deser dut (
      .clk        (clk),
      .rst        (rst),
      .sync_i     (sync_i),
      .sdata_i    (sdata_i),
      .dac_word_o (dac_word_o),
      .dac_sel_o  (dac_sel_o),
      .dac_stb_o  (dac_stb_o),
      .ctrl0_o    (ctrl0_o),
      .ctrl1_o    (ctrl1_o),
      .ctrl_stb_o (ctrl_stb_o)
   );

   always #(CLK_P / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_ctrl(input logic [47:0] f, input string req);
      chk(ctrl_stb_o && ctrl0_o == f[31:24] && ctrl1_o == f[7:0], req,
          {47'd0, ctrl_stb_o, ctrl0_o, ctrl1_o}, {47'd0, 1'b1, f[31:24], f[7:0]});
   endtask

   // Each negedge at loop index k comes after the edge that took bit k-1.
   task automatic run_frame(input logic [47:0] f, input bit do_start, input bit chain, input bit glitch);
      if (do_start) begin
         @(negedge clk);
         sync_i  = 1'b1;
         sdata_i = 1'b0;
      end
      for (int k = 0; k < 48; k++) begin
         @(negedge clk);
         if (k == 0 && pend) begin
            chk_ctrl(pend_f, "R7 ctrl update at back-to-back boundary");
            pend = 1'b0;
         end else begin
            chk(!ctrl_stb_o, "R6 no ctrl strobe mid-frame", {63'd0, ctrl_stb_o}, 64'd0);
         end
         if (k == 16)
            chk(dac_stb_o && !dac_sel_o && dac_word_o == f[47:32], "R4 word0 after bit 15",
                {46'd0, dac_stb_o, dac_sel_o, dac_word_o}, {46'd0, 1'b1, 1'b0, f[47:32]});
         else if (k == 40)
            chk(dac_stb_o && dac_sel_o && dac_word_o == f[23:8], "R5 word1 after bit 39",
                {46'd0, dac_stb_o, dac_sel_o, dac_word_o}, {46'd0, 1'b1, 1'b1, f[23:8]});
         else
            chk(!dac_stb_o, "R9 DAC strobe only at word ends", {63'd0, dac_stb_o}, 64'd0);
         sdata_i = f[47 - k];
         if (k == 47)     sync_i = chain;
         else if (glitch) sync_i = (k % 7 == 3) || (k > 41);
         else             sync_i = 1'b0;
      end
      if (chain) begin
         pend   = 1'b1;
         pend_f = f;
      end else begin
         @(negedge clk);
         sync_i  = 1'b0;
         chk_ctrl(f, "R6 ctrl bytes at frame end");
      end
   endtask

   task automatic idle_watch(input int n, input string req);
      bit quiet = 1'b1;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         sdata_i = ~sdata_i;
         if (dac_stb_o || ctrl_stb_o) quiet = 1'b0;
      end
      chk(quiet, req, {63'd0, quiet}, 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dac_word_o == 0 && !dac_sel_o && !dac_stb_o && ctrl0_o == 0 && ctrl1_o == 0 && !ctrl_stb_o,
          "R1 reset state", {30'd0, dac_word_o, dac_sel_o, dac_stb_o, ctrl0_o, ctrl1_o, ctrl_stb_o}, 64'd0);
      rst = 1'b0;
      idle_watch(10, "R1 idle without sync");

      // Table walk: R2, R4, R5, R6, R8 on every frame; R7 and R3 per mode
      for (int i = 0; i < NV; i++) begin
         run_frame(VEC[i], !(i > 0 && MODE[i-1][1]), MODE[i][1], MODE[i][0]);
         if (!MODE[i][1]) idle_watch(5, "R3 idle after frame end with sync low");
      end

      // R1: reset in the middle of a frame
      @(negedge clk);
      sync_i = 1'b1;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         sync_i  = 1'b0;
         sdata_i = k[0];
      end
      rst = 1'b1;
      @(negedge clk);
      chk(dac_word_o == 0 && ctrl0_o == 0 && ctrl1_o == 0 && !dac_stb_o && !ctrl_stb_o,
          "R1 outputs cleared by mid-frame reset", {32'd0, dac_word_o, ctrl0_o, ctrl1_o}, 64'd0);
      rst = 1'b0;
      idle_watch(60, "R1 frame dropped by reset, waiting for sync");

      // R2 / R8: single-cycle sync restarts cleanly after reset
      run_frame(48'h0001_80_FFFE_01, 1'b1, 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule